// File: doc/BRIEF.md
# Oscillator Fault Monitor with Fallback

This block supervises the clock sources of a clock system: two high-frequency external inputs, one low-frequency external input, and the tap code of an internal controlled oscillator. Each external input reaches the block as a one-cycle tick, one per observed oscillation, already sampled into the reference clock domain. Each source has a sticky fault flag. A combined fault flag gathers all of them and feeds an interrupt request.

Software requests a clock source through a small write port. The block drives the effective select of a downstream clock multiplexer. If the requested external source has faulted, the effective select falls back to the internal oscillator (code 0). It stays there until the combined flag is cleared, or until software selects a source whose own flag is already clear. A per-source flag can only be cleared once that source has shown a long unbroken run of oscillations. The combined flag can only be cleared when every per-source flag is clear.

Each external input has a monitor with two named states. In MON_WAIT the monitor counts consecutive good ticks. The transition MON_WAIT to MON_GOOD happens on the tick that completes the run. Any timeout moves MON_GOOD (or MON_WAIT) back to MON_WAIT with the count at zero. The fallback controller also has two named states. FB_RUN passes the requested source through. FB_HOLD forces the internal oscillator. The transition FB_RUN to FB_HOLD occurs when the requested source is external and its flag is set or being set. The transition FB_HOLD to FB_RUN occurs when the combined flag is clear, or on a select write to a healthy source.

Top module: `osc_fault_monitor`

## Requirements
- R1: After reset, src_fault reads 4'b1110, any_fault is 1, eff_src is 0 and fault_irq is 0. Flag bit positions: bit 0 is the internal oscillator, bit 1 is HF0, bit 2 is HF1, bit 3 is LF. Source codes use the same numbers.
- R2: A clear of an HF flag is ignored until that source has given 1024 consecutive ticks with no timeout in between. After that, the clear takes effect at the write edge.
- R3: The LF flag follows the same rule as R2, but needs 8192 consecutive ticks.
- R4: The timeout limit register (address 3) holds a count N, which is 16 after reset. When an external source has N cycles without a tick and then another cycle without one, its flag is set and its run of good ticks restarts from zero.
- R5: While osc_tap is 0 or 31, the internal-oscillator flag is set and a clear of it is ignored.
- R6: Writing bit 4 to the clear register (address 2'd1) clears any_fault only if all four flags are clear before that write. Any new fault event sets any_fault. Clear bits 3:0 address flags 3:0.
- R7: If the selected external source faults, or a select write (address 0, data bits 1:0) names an external source whose flag is set, eff_src becomes 0 at that edge.
- R8: Once fallen back, eff_src stays 0 after the faulted source's own flag is cleared. It returns to the requested source on the cycle after any_fault is cleared.
- R9: A select write naming a source whose own flag is clear sets eff_src to that source at the write edge, even while any_fault is set.
- R10: fault_irq is any_fault AND the enable bit (address 2, data bit 0). It drops the cycle after a successful clear of any_fault.
- R11: A fault event in the same cycle as a clear of that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf0_tick | input | 1 | One pulse per oscillation of high-frequency source 0 |
| hf1_tick | input | 1 | One pulse per oscillation of high-frequency source 1 |
| lf_tick | input | 1 | One pulse per oscillation of the low-frequency source |
| osc_tap | input | TAP_W | Internal oscillator tap code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 select, 1 clear, 2 enable, 3 timeout |
| reg_wdata | input | 8 | Register write data |
| eff_src | output | 2 | Effective clock multiplexer select |
| src_fault | output | 4 | Per-source fault flags |
| any_fault | output | 1 | Combined fault flag |
| fault_irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle: a fault event setting a flag, and a software clear aimed at that same flag. A second such pair is a combined-flag clear issued while a per-source flag is still set. The bench forces the first case by moving the tap code to zero on the very cycle that clears the internal flag, and it expects the flag to stay set. It forces the second by clearing the combined flag while the HF1 and LF flags remain set. A behavioural model, updated on every edge, predicts all outputs, and the bench compares them against the block each cycle alongside directed checks at these points.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_HF0 = 2'd1,
        SRC_HF1 = 2'd2,
        SRC_LF  = 2'd3
    } src_e;

    typedef enum logic {
        MON_WAIT,
        MON_GOOD
    } mon_state_e;

    typedef enum logic {
        FB_RUN,
        FB_HOLD
    } fb_state_e;

    localparam int NSRC = 4;

    localparam logic [1:0] ADDR_SEL = 2'd0;
    localparam logic [1:0] ADDR_CLR = 2'd1;
    localparam logic [1:0] ADDR_IE  = 2'd2;
    localparam logic [1:0] ADDR_TMO = 2'd3;

    localparam int CLR_COMB_BIT = 4;

endpackage

// File: rtl/osc_edge_monitor.sv
module osc_edge_monitor
    import osc_mon_pkg::*;
#(
    parameter int GOOD_CNT = 1024,
    parameter int TMO_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [TMO_W-1:0] tmo,
    input  logic             clr_req,
    output logic             fault_flag,
    output logic             fault_evt
);

    localparam int CNT_W = $clog2(GOOD_CNT + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GOOD_CNT - 1);

    mon_state_e       state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic [TMO_W-1:0] gap_q, gap_d;
    logic             flag_q, flag_d;
    logic             timeout;

    assign timeout = !tick && (gap_q >= tmo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_WAIT;
            run_q   <= '0;
            gap_q   <= '0;
            flag_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            gap_q   <= gap_d;
            flag_q  <= flag_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            MON_WAIT: begin
                if (timeout) begin
                    run_d = '0;
                end else if (tick) begin
                    if (run_q == LAST_CNT) begin
                        state_d = MON_GOOD;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
            end
            MON_GOOD: begin
                if (timeout) begin
                    state_d = MON_WAIT;
                    run_d   = '0;
                end
            end
        endcase

        if (tick || timeout) gap_d = '0;
        else                 gap_d = gap_q + 1'b1;

        flag_d = timeout || (flag_q && !(clr_req && state_q == MON_GOOD));
    end

    always_comb begin
        fault_flag = flag_q;
        fault_evt  = timeout;
    end

endmodule

// File: rtl/osc_tap_monitor.sv
module osc_tap_monitor #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] tap,
    input  logic             clr_req,
    output logic             fault_flag,
    output logic             fault_evt
);

    logic flag_q;
    logic at_limit;

    assign at_limit = (tap == '0) || (tap == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= at_limit || (flag_q && !clr_req);
    end

    always_comb begin
        fault_flag = flag_q;
        fault_evt  = at_limit;
    end

endmodule

// File: rtl/osc_fallback_fsm.sv
module osc_fallback_fsm
    import osc_mon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_wr,
    input  src_e            sel_data,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] evts,
    input  logic            comb_flag,
    output src_e            eff_sel
);

    fb_state_e       state_q, state_d;
    src_e            req_q, req_d;
    logic [NSRC-1:0] unhealthy;

    assign unhealthy = (flags | evts) & ~NSRC'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FB_RUN;
            req_q   <= SRC_INT;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
        end
    end

    always_comb begin
        state_d = state_q;
        req_d   = req_q;
        if (sel_wr) begin
            req_d   = sel_data;
            state_d = unhealthy[sel_data] ? FB_HOLD : FB_RUN;
        end else begin
            unique case (state_q)
                FB_RUN:  if (unhealthy[req_q]) state_d = FB_HOLD;
                FB_HOLD: if (!comb_flag && !unhealthy[req_q]) state_d = FB_RUN;
            endcase
        end
    end

    always_comb begin
        eff_sel = (state_q == FB_HOLD) ? SRC_INT : req_q;
    end

endmodule

// File: rtl/osc_fault_monitor.sv
module osc_fault_monitor
    import osc_mon_pkg::*;
#(
    parameter int HF_GOOD = 1024,
    parameter int LF_GOOD = 8192,
    parameter int TMO_W   = 8,
    parameter int TMO_RST = 16,
    parameter int TAP_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hf0_tick,
    input  logic             hf1_tick,
    input  logic             lf_tick,
    input  logic [TAP_W-1:0] osc_tap,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [1:0]       eff_src,
    output logic [3:0]       src_fault,
    output logic             any_fault,
    output logic             fault_irq
);

    localparam int NEXT = NSRC - 1;

    logic [NEXT-1:0]  ext_tick;
    logic [NSRC-1:0]  flag_v, evt_v, clr_v;
    logic             clr_comb, sel_wr;
    logic             comb_q, ie_q;
    logic [TMO_W-1:0] tmo_q;
    src_e             eff_sel;

    assign ext_tick = {lf_tick, hf1_tick, hf0_tick};
    assign sel_wr   = reg_we && (reg_addr == ADDR_SEL);
    assign clr_v    = (reg_we && reg_addr == ADDR_CLR) ? reg_wdata[NSRC-1:0] : '0;
    assign clr_comb = reg_we && (reg_addr == ADDR_CLR) && reg_wdata[CLR_COMB_BIT];

    osc_tap_monitor #(.TAP_W(TAP_W)) tap_mon_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tap        (osc_tap),
        .clr_req    (clr_v[0]),
        .fault_flag (flag_v[0]),
        .fault_evt  (evt_v[0])
    );

    for (genvar gi = 0; gi < NEXT; gi++) begin : g_ext
        localparam int GOOD = (gi == NEXT - 1) ? LF_GOOD : HF_GOOD;
        osc_edge_monitor #(.GOOD_CNT(GOOD), .TMO_W(TMO_W)) mon_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (ext_tick[gi]),
            .tmo        (tmo_q),
            .clr_req    (clr_v[gi+1]),
            .fault_flag (flag_v[gi+1]),
            .fault_evt  (evt_v[gi+1])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comb_q <= 1'b1;
            ie_q   <= 1'b0;
            tmo_q  <= TMO_W'(TMO_RST);
        end else begin
            if (|evt_v)                       comb_q <= 1'b1;
            else if (clr_comb && flag_v == '0) comb_q <= 1'b0;
            if (reg_we && reg_addr == ADDR_IE)  ie_q  <= reg_wdata[0];
            if (reg_we && reg_addr == ADDR_TMO) tmo_q <= reg_wdata[TMO_W-1:0];
        end
    end

    osc_fallback_fsm fb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_data  (src_e'(reg_wdata[1:0])),
        .flags     (flag_v),
        .evts      (evt_v),
        .comb_flag (comb_q),
        .eff_sel   (eff_sel)
    );

    assign eff_src   = eff_sel;
    assign src_fault = flag_v;
    assign any_fault = comb_q;
    assign fault_irq = comb_q && ie_q;

endmodule

// File: rtl/osc_fault_monitor_chk.sv
module osc_fault_monitor_chk #(
    parameter int TAP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAP_W-1:0] osc_tap,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [1:0]       eff_src,
    input logic [3:0]       src_fault,
    input logic             any_fault,
    input logic             fault_irq
);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |-> any_fault);

    // R6
    comb_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_fault && (|src_fault)) |=> any_fault);

    // R5
    tap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tap == '0 || osc_tap == '1) |=> src_fault[0]);

    // R7
    no_faulty_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_src != 2'd0) |-> !src_fault[eff_src]);

    // R8
    fallback_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_src == 2'd0 && any_fault && !(reg_we && reg_addr == 2'd0)) |=> (eff_src == 2'd0));

endmodule

bind osc_fault_monitor osc_fault_monitor_chk #(.TAP_W(TAP_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tap   (osc_tap),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .eff_src   (eff_src),
    .src_fault (src_fault),
    .any_fault (any_fault),
    .fault_irq (fault_irq)
);

// File: tb/osc_fault_monitor_tb.sv
module osc_fault_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hf0_tick = 1'b0, hf1_tick = 1'b0, lf_tick = 1'b0;
    logic [4:0] osc_tap = 5'd16;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [1:0] eff_src;
    logic [3:0] src_fault;
    logic       any_fault, fault_irq;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 0;
    bit done = 0;
    int per[3] = '{0, 0, 0};
    int cyc = 0;

    // behavioural reference state
    int m_flag[4];
    int m_gap[4];
    int m_run[4];
    int m_comb, m_ie, m_sel, m_fb, m_tmo;
    int limit[4] = '{0, 1024, 1024, 8192};

    always #10 clk = ~clk;

    osc_fault_monitor dut_i (
        .clk(clk), .rst_n(rst_n),
        .hf0_tick(hf0_tick), .hf1_tick(hf1_tick), .lf_tick(lf_tick),
        .osc_tap(osc_tap), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .eff_src(eff_src), .src_fault(src_fault), .any_fault(any_fault), .fault_irq(fault_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '{0, 1, 1, 1};
            m_gap = '{0, 0, 0, 0};
            m_run = '{0, 0, 0, 0};
            m_comb = 1; m_ie = 0; m_sel = 0; m_fb = 0; m_tmo = 16;
        end else begin
            int ev[4];
            int ok[4];
            int old_flag[4];
            int tk[4];
            int any_old, any_ev, clrs, hot;
            tk = '{0, int'(hf0_tick), int'(hf1_tick), int'(lf_tick)};
            old_flag = m_flag;
            ev[0] = (osc_tap == 0 || osc_tap == 31);
            ok[0] = 1;
            for (int s = 1; s < 4; s++) begin
                ok[s] = (m_run[s] >= limit[s]);
                ev[s] = 0;
                if (tk[s] != 0) begin
                    m_gap[s] = 0;
                    if (m_run[s] < limit[s]) m_run[s]++;
                end else if (m_gap[s] >= m_tmo) begin
                    ev[s] = 1; m_gap[s] = 0; m_run[s] = 0;
                end else m_gap[s]++;
            end
            clrs = (reg_we && reg_addr == 1) ? int'(reg_wdata) : 0;
            any_old = 0; any_ev = 0;
            for (int s = 0; s < 4; s++) begin
                if (old_flag[s] != 0) any_old = 1;
                if (ev[s] != 0) any_ev = 1;
                if (ev[s] != 0) m_flag[s] = 1;
                else if (clrs[s] && ok[s] != 0) m_flag[s] = 0;
            end
            if (reg_we && reg_addr == 0) begin
                m_sel = reg_wdata[1:0];
                m_fb = (m_sel != 0) && (old_flag[m_sel] != 0 || ev[m_sel] != 0);
            end else begin
                hot = (m_sel != 0) && (old_flag[m_sel] != 0 || ev[m_sel] != 0);
                if (m_fb == 0) m_fb = hot;
                else if (m_comb == 0 && hot == 0) m_fb = 0;
            end
            if (any_ev != 0) m_comb = 1;
            else if (clrs[4] && any_old == 0) m_comb = 0;
            if (reg_we && reg_addr == 2) m_ie = reg_wdata[0];
            if (reg_we && reg_addr == 3) m_tmo = reg_wdata;
        end
    end

    // tick generators and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        hf0_tick <= (per[0] != 0) && (cyc % per[0] == 0);
        hf1_tick <= (per[1] != 0) && (cyc % per[1] == 0);
        lf_tick  <= (per[2] != 0) && (cyc % per[2] == 0);
        if (cmp_on) begin
            chk("R8 eff_src", int'(eff_src), (m_fb != 0) ? 0 : m_sel);
            chk("R5 internal flag", int'(src_fault[0]), m_flag[0]);
            chk("R2 hf0 flag", int'(src_fault[1]), m_flag[1]);
            chk("R2 hf1 flag", int'(src_fault[2]), m_flag[2]);
            chk("R3 lf flag", int'(src_fault[3]), m_flag[3]);
            chk("R6 any_fault", int'(any_fault), m_comb);
            chk("R10 fault_irq", int'(fault_irq), m_comb & m_ie);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        chk("R1 flags", int'(src_fault), 14);
        chk("R1 any_fault", int'(any_fault), 1);
        chk("R1 eff_src", int'(eff_src), 0);
        chk("R1 fault_irq", int'(fault_irq), 0);
        cmp_on = 1;

        wr(2'd2, 8'h01);
        chk("R10 irq on enable", int'(fault_irq), 1);

        per[0] = 2;
        idle(100);
        wr(2'd1, 8'h02);
        chk("R2 early clear ignored", int'(src_fault[1]), 1);
        idle(2100);
        wr(2'd1, 8'h02);
        chk("R2 clear after run", int'(src_fault[1]), 0);

        wr(2'd0, 8'h01);
        chk("R9 switch while combined set", int'(eff_src), 1);
        wr(2'd1, 8'h10);
        chk("R6 combined clear blocked", int'(any_fault), 1);

        per[0] = 0;
        idle(40);
        chk("R7 fault forces internal", int'(eff_src), 0);
        chk("R7 hf0 flag set", int'(src_fault[1]), 1);

        per[0] = 2;
        idle(2100);
        wr(2'd1, 8'h02);
        chk("R8 own clear done", int'(src_fault[1]), 0);
        idle(3);
        chk("R8 still fallen back", int'(eff_src), 0);

        per[1] = 3; per[2] = 2;
        idle(16500);
        wr(2'd1, 8'h0E);
        chk("R3 all flags clear", int'(src_fault), 0);
        wr(2'd1, 8'h10);
        chk("R6 combined cleared", int'(any_fault), 0);
        chk("R10 irq dropped", int'(fault_irq), 0);
        idle(2);
        chk("R8 returns to request", int'(eff_src), 1);

        osc_tap = 5'd31;
        idle(2);
        chk("R5 tap max sets flag", int'(src_fault[0]), 1);
        chk("R6 fault event sets combined", int'(any_fault), 1);
        wr(2'd1, 8'h01);
        chk("R5 clear ignored at limit", int'(src_fault[0]), 1);
        osc_tap = 5'd7;
        idle(1);
        @(negedge clk);
        osc_tap = 5'd0;
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R11 set beats clear", int'(src_fault[0]), 1);
        osc_tap = 5'd9;
        idle(1);
        wr(2'd1, 8'h01);
        chk("R5 clear away from limit", int'(src_fault[0]), 0);

        wr(2'd3, 8'd2);
        idle(30);
        chk("R4 hf1 healthy with tight limit", int'(src_fault[2]), 0);
        per[1] = 5;
        idle(20);
        chk("R4 timeout sets flag", int'(src_fault[2]), 1);
        per[1] = 3;
        idle(60);
        wr(2'd1, 8'h04);
        chk("R4 run restarted", int'(src_fault[2]), 1);
        chk("R9 hf0 still routed", int'(eff_src), 1);

        idle(5);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule